// File: doc/BRIEF.md
# Two-Buffer Lock Handoff Controller

This block arbitrates two data buffers, each placed in its own memory bank, between one producing agent and one consuming agent. Every buffer carries a lock with two states: empty and writable, or loaded and readable. The producer claims an empty buffer, writes into it while holding exclusive ownership, and hands it over as loaded together with the number of valid entries. The consumer claims a loaded buffer, reads that entry count alongside its grant, drains the data, and returns the buffer as empty.

Each side works through the two buffers in turn, moving to the other index after every hand-back. Because the buffers sit in separate banks, the producer can fill one while the consumer drains the other. Under matched rates the two agents therefore run at the same time instead of waiting on each other. A claim on a buffer in the wrong lock state is held pending until the other side releases it. A protocol misuse raises a one-cycle error pulse and is otherwise ignored. The memory banks and the computation on either side lie outside this block.

Top module: `pp_lock_ctrl`

## Requirements
- R1: After synchronous reset, both locks are empty, `prod_idx` and `cons_idx` are 0, and `prod_hold`, `cons_hold`, both grants and both error outputs are 0.
- R2: A producer claim pulse, sampled while the producer holds nothing and has no claim pending, and while the buffer at `prod_idx` is empty, is granted at that same clock edge. `prod_gnt` is 1 and `prod_hold` is 1 in the following cycle.
- R3: A producer claim on a loaded buffer stays pending without a grant. The grant comes at the first edge after the edge at which the consumer releases that buffer.
- R4: A consumer claim on an empty buffer stays pending without a grant. The grant comes at the first edge after the edge at which the producer releases that buffer as loaded.
- R5: A producer release with a count from 1 to BUF_DEPTH marks its buffer loaded, stores the count, clears `prod_hold` and toggles `prod_idx` at that edge.
- R6: While `cons_hold` is 1, `cons_cnt` shows the count stored by the producer's release of buffer `cons_idx`. Otherwise it is 0.
- R7: A consumer release while holding marks its buffer empty, clears `cons_hold` and toggles `cons_idx` at that edge.
- R8: The following misuses cause the matching error output to be 1 for exactly the cycle after the edge that sampled them, and change no index, hold or lock: a claim while holding or pending, a release while not holding, and a producer release with count 0 or a count above BUF_DEPTH.
- R9: The producer and the consumer may hold the two different buffers at the same time. They never hold the same buffer together.
- R10: Each grant output is high for exactly one cycle per accepted claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prod_acq | input | 1 | Producer claim pulse |
| prod_rel | input | 1 | Producer hand-over pulse |
| prod_rel_cnt | input | CNT_W | Entry count handed over with `prod_rel` |
| prod_gnt | output | 1 | Producer claim granted (one cycle) |
| prod_hold | output | 1 | Producer owns buffer `prod_idx` |
| prod_idx | output | 1 | Producer's current buffer index |
| prod_err | output | 1 | Producer protocol misuse pulse |
| cons_acq | input | 1 | Consumer claim pulse |
| cons_rel | input | 1 | Consumer return pulse |
| cons_gnt | output | 1 | Consumer claim granted (one cycle) |
| cons_hold | output | 1 | Consumer owns buffer `cons_idx` |
| cons_idx | output | 1 | Consumer's current buffer index |
| cons_cnt | output | CNT_W | Entry count of the held buffer |
| cons_err | output | 1 | Consumer protocol misuse pulse |

## Verification
The bench drives the stall cases in both directions and samples the exact cycle in which each pending claim turns into a grant. A design that checked the lock one edge late or one edge early would show the grant in the wrong cycle. It sweeps every producer hand-over count from 0 to one past the buffer depth. A boundary error there would either accept an illegal count or flag the legal extremes, and the count is checked again on the consumer's grant. Each misuse is followed by a look at the indices and holds, to catch a design that flags the error but still toggles its index or drops ownership.

// File: rtl/pp_lock_pkg.sv
package pp_lock_pkg;

    localparam int NBUF = 2;

    typedef enum logic {
        LK_EMPTY  = 1'b0,
        LK_LOADED = 1'b1
    } lock_e;

    typedef logic buf_idx_t;

    function automatic logic count_legal(input logic [31:0] cnt, input int depth);
        return (cnt != 32'd0) && (cnt <= 32'(depth));
    endfunction

endpackage

// File: rtl/pp_lock_bank.sv
module pp_lock_bank
    import pp_lock_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             p_commit,
    input  buf_idx_t         p_idx,
    input  logic [CNT_W-1:0] p_cnt,
    input  logic             c_commit,
    input  buf_idx_t         c_idx,
    output lock_e            state_o [NBUF],
    output logic [CNT_W-1:0] cnt_o   [NBUF]
);

    lock_e            state_q [NBUF];
    logic [CNT_W-1:0] cnt_q   [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[b] <= LK_EMPTY;
                cnt_q[b]   <= '0;
            end else if (p_commit && (int'(p_idx) == b)) begin
                state_q[b] <= LK_LOADED;
                cnt_q[b]   <= p_cnt;
            end else if (c_commit && (int'(c_idx) == b)) begin
                state_q[b] <= LK_EMPTY;
            end
        end
        assign state_o[b] = state_q[b];
        assign cnt_o[b]   = cnt_q[b];
    end

    AST_PROD_REL_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        p_commit |-> state_q[p_idx] == LK_EMPTY); // R5
    AST_CONS_REL_ON_LOADED: assert property (@(posedge clk) disable iff (rst)
        c_commit |-> state_q[c_idx] == LK_LOADED); // R7
    AST_NO_SAME_BUF_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(p_commit && c_commit && p_idx == c_idx)); // R9

endmodule

// File: rtl/pp_side.sv
module pp_side
    import pp_lock_pkg::*;
#(
    parameter int    CNT_W     = 5,
    parameter int    DEPTH     = 16,
    parameter lock_e WANT      = LK_EMPTY,
    parameter bit    CHECK_CNT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq_i,
    input  logic             rel_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  lock_e            lock_i [NBUF],
    output buf_idx_t         idx_o,
    output logic             hold_o,
    output logic             gnt_o,
    output logic             commit_o,
    output logic             err_o
);

    buf_idx_t idx_q;
    logic     hold_q, pend_q, gnt_q, err_q;
    logic     acq_bad, rel_bad, cnt_ok, want, take;

    always_comb begin
        cnt_ok   = CHECK_CNT ? count_legal(32'(cnt_i), DEPTH) : 1'b1;
        acq_bad  = acq_i && (hold_q || pend_q);
        rel_bad  = rel_i && (!hold_q || !cnt_ok);
        commit_o = rel_i && hold_q && cnt_ok;
        want     = (acq_i && !acq_bad) || pend_q;
        take     = want && !hold_q && (lock_i[idx_q] == WANT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= 1'b0;
            hold_q <= 1'b0;
            pend_q <= 1'b0;
            gnt_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            pend_q <= want && !take;
            gnt_q  <= take;
            err_q  <= acq_bad || rel_bad;
            if (take) begin
                hold_q <= 1'b1;
            end else if (commit_o) begin
                hold_q <= 1'b0;
                idx_q  <= ~idx_q;
            end
        end
    end

    assign idx_o  = idx_q;
    assign hold_o = hold_q;
    assign gnt_o  = gnt_q;
    assign err_o  = err_q;

    AST_GRANT_ON_RIGHT_LOCK: assert property (@(posedge clk) disable iff (rst)
        gnt_o |-> lock_i[idx_o] == WANT); // R3
    AST_IDX_MOVES_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> idx_o != $past(idx_o)); // R7
    AST_GRANT_MEANS_HOLD: assert property (@(posedge clk) disable iff (rst)
        gnt_o |-> hold_o); // R2

endmodule

// File: rtl/pp_lock_ctrl.sv
module pp_lock_ctrl
    import pp_lock_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int CNT_W     = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prod_acq,
    input  logic             prod_rel,
    input  logic [CNT_W-1:0] prod_rel_cnt,
    output logic             prod_gnt,
    output logic             prod_hold,
    output logic             prod_idx,
    output logic             prod_err,
    input  logic             cons_acq,
    input  logic             cons_rel,
    output logic             cons_gnt,
    output logic             cons_hold,
    output logic             cons_idx,
    output logic [CNT_W-1:0] cons_cnt,
    output logic             cons_err
);

    lock_e            lock_st [NBUF];
    logic [CNT_W-1:0] lock_cnt [NBUF];
    logic             p_commit, c_commit;
    buf_idx_t         p_idx, c_idx;

    pp_side #(
        .CNT_W(CNT_W), .DEPTH(BUF_DEPTH), .WANT(LK_EMPTY), .CHECK_CNT(1'b1)
    ) i_prod (
        .clk(clk), .rst(rst), .acq_i(prod_acq), .rel_i(prod_rel),
        .cnt_i(prod_rel_cnt), .lock_i(lock_st), .idx_o(p_idx),
        .hold_o(prod_hold), .gnt_o(prod_gnt), .commit_o(p_commit), .err_o(prod_err)
    );

    pp_side #(
        .CNT_W(CNT_W), .DEPTH(BUF_DEPTH), .WANT(LK_LOADED), .CHECK_CNT(1'b0)
    ) i_cons (
        .clk(clk), .rst(rst), .acq_i(cons_acq), .rel_i(cons_rel),
        .cnt_i('0), .lock_i(lock_st), .idx_o(c_idx),
        .hold_o(cons_hold), .gnt_o(cons_gnt), .commit_o(c_commit), .err_o(cons_err)
    );

    pp_lock_bank #(.CNT_W(CNT_W)) i_bank (
        .clk(clk), .rst(rst),
        .p_commit(p_commit), .p_idx(p_idx), .p_cnt(prod_rel_cnt),
        .c_commit(c_commit), .c_idx(c_idx),
        .state_o(lock_st), .cnt_o(lock_cnt)
    );

    assign prod_idx = p_idx;
    assign cons_idx = c_idx;
    assign cons_cnt = cons_hold ? lock_cnt[c_idx] : '0;

    AST_EXCLUSIVE_OWNER: assert property (@(posedge clk) disable iff (rst)
        !(prod_hold && cons_hold && (prod_idx == cons_idx))); // R9
    AST_PROD_GNT_PULSE: assert property (@(posedge clk) disable iff (rst)
        prod_gnt |=> !prod_gnt); // R10
    AST_CONS_GNT_PULSE: assert property (@(posedge clk) disable iff (rst)
        cons_gnt |=> !cons_gnt); // R10

endmodule

// File: tb/test_pp_lock_ctrl.sv
module test_pp_lock_ctrl;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic prod_acq = 0, prod_rel = 0, cons_acq = 0, cons_rel = 0;
    logic [CW-1:0] prod_rel_cnt = '0;
    logic prod_gnt, prod_hold, prod_idx, prod_err;
    logic cons_gnt, cons_hold, cons_idx, cons_err;
    logic [CW-1:0] cons_cnt;
    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pp_lock_ctrl #(.BUF_DEPTH(DEPTH)) i_pp_lock_ctrl (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_p_acq();
        @(negedge clk) prod_acq = 1; @(negedge clk) prod_acq = 0;
    endtask
    task automatic pulse_p_rel(input int c);
        @(negedge clk) begin prod_rel = 1; prod_rel_cnt = CW'(c); end
        @(negedge clk) prod_rel = 0;
    endtask
    task automatic pulse_c_acq();
        @(negedge clk) cons_acq = 1; @(negedge clk) cons_acq = 0;
    endtask
    task automatic pulse_c_rel();
        @(negedge clk) cons_rel = 1; @(negedge clk) cons_rel = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pi, ci;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 prod_idx", prod_idx, 0); chk("R1 cons_idx", cons_idx, 0);
        chk("R1 prod_hold", prod_hold, 0); chk("R1 cons_hold", cons_hold, 0);
        chk("R1 errs", {prod_err, cons_err}, 0); chk("R1 gnts", {prod_gnt, cons_gnt}, 0);
        // R4 consumer claims an empty buffer: pends
        pulse_c_acq();
        chk("R4 cons pend gnt", cons_gnt, 0); chk("R4 cons pend hold", cons_hold, 0);
        // R2 producer claim granted
        pulse_p_acq();
        chk("R2 prod_gnt", prod_gnt, 1); chk("R2 prod_hold", prod_hold, 1);
        chk("R2 prod_idx", prod_idx, 0);
        @(negedge clk);
        chk("R10 prod_gnt pulse", prod_gnt, 0);
        // R5 release count 5
        pulse_p_rel(5);
        chk("R5 prod_hold", prod_hold, 0); chk("R5 prod_idx", prod_idx, 1);
        chk("R4 cons not yet", cons_gnt, 0);
        @(negedge clk);
        chk("R4 cons gnt", cons_gnt, 1); chk("R4 cons_hold", cons_hold, 1);
        chk("R6 cons_cnt", cons_cnt, 5); chk("R4 cons_idx", cons_idx, 0);
        @(negedge clk);
        chk("R10 cons_gnt pulse", cons_gnt, 0);
        // R9 concurrent ownership
        pulse_p_acq();
        chk("R9 prod hold", prod_hold, 1); chk("R9 cons hold", cons_hold, 1);
        chk("R9 idx differ", prod_idx != cons_idx, 1);
        pulse_p_rel(7);
        chk("R5 idx back", prod_idx, 0);
        // R3 producer claims loaded buffer 0: stalls
        pulse_p_acq();
        repeat (3) begin
            chk("R3 stall gnt", prod_gnt, 0); chk("R3 stall hold", prod_hold, 0);
            @(negedge clk);
        end
        pulse_c_rel();
        chk("R7 cons_idx", cons_idx, 1); chk("R7 cons_hold", cons_hold, 0);
        chk("R6 cnt cleared", cons_cnt, 0);
        chk("R3 not yet", prod_gnt, 0);
        @(negedge clk);
        chk("R3 prod gnt", prod_gnt, 1); chk("R3 prod_hold", prod_hold, 1);
        // consumer takes loaded buffer 1 at once
        pulse_c_acq();
        chk("R6 cons gnt b1", cons_gnt, 1); chk("R6 cons_cnt b1", cons_cnt, 7);
        // R8 claim while holding
        pulse_p_acq();
        chk("R8 p_acq err", prod_err, 1); chk("R8 p_acq hold", prod_hold, 1);
        chk("R8 p_acq idx", prod_idx, 0);
        @(negedge clk);
        chk("R8 err pulse", prod_err, 0);
        pulse_c_rel();
        chk("R7 cons_idx 0", cons_idx, 0);
        // R8 release while not holding
        pulse_c_rel();
        chk("R8 c_rel err", cons_err, 1); chk("R8 c_rel idx", cons_idx, 0);
        // R8 claim while pending (buffer 0 is held by producer, so empty)
        pulse_c_acq();
        pulse_c_acq();
        chk("R8 c_acq pend err", cons_err, 1); chk("R8 c_acq no hold", cons_hold, 0);
        // R5/R8 sweep of release counts; consumer pending on buffer 0
        pi = 0; ci = 0;
        for (int c = 0; c <= DEPTH + 1; c++) begin
            bit ok;
            ok = (c >= 1) && (c <= DEPTH);
            pulse_p_rel(c);
            chk($sformatf("R8 cnt %0d err", c), prod_err, ok ? 0 : 1);
            chk($sformatf("R5 cnt %0d hold", c), prod_hold, ok ? 0 : 1);
            if (ok) pi ^= 1;
            chk($sformatf("R5 cnt %0d idx", c), prod_idx, pi);
            if (ok) begin
                if (c != 1) pulse_c_acq();
                else @(negedge clk);
                chk($sformatf("R6 cnt %0d", c), cons_cnt, c);
                chk($sformatf("R4 idx %0d", c), cons_idx, ci);
                pulse_c_rel();
                ci ^= 1;
                chk($sformatf("R7 idx %0d", c), cons_idx, ci);
                pulse_p_acq();
                chk($sformatf("R2 regrant %0d", c), prod_gnt, 1);
            end
        end
        // R8 producer release while not holding
        pulse_p_rel(3);
        pulse_p_rel(3);
        chk("R8 p_rel idle err", prod_err, 1);
        chk("R8 p_rel idle idx", prod_idx, pi ^ 1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule